// File: doc/BRIEF.md
# Per-Core Local Interrupt Controller

A register-mapped interrupt concentrator for a cluster of up to four cores. Each core has four timer request inputs, a peripheral request input and a performance-monitor request input. It also has one 32-bit doorbell mailbox that any agent can ring through the register bus. Per-core enable masks select which sources raise that core's interrupt line. A shared routing mask, with one bit per core, gates the performance-monitor requests.

Software rings a doorbell by writing a one-hot word to the target core's set address. The target reads its status word and services the lowest set bit first. It acknowledges a doorbell by writing the same bits to its clear address. The register bus has no wait states: writes take effect at the clock edge, and reads return data combinationally from the current address.

Top module: `core_irq_ctrl`

## Requirements
- R1: Reset clears all timer enables, all mailbox enables, every mailbox word, the routing mask and every `irq` output.
- R2: The timer enable register of core c is at byte address 0x40+4c. Bits 3:0 are read/write and enable, in order, the secure physical, non-secure physical, hypervisor and virtual timers (`timer_irq[4c+j]`). The upper bits read as 0.
- R3: Writing to 0x80+16c sets every mailbox bit of core c whose write-data bit is 1. Bits written as 0 are unchanged. A read at this address returns the mailbox.
- R4: Writing to 0xC0+16c clears every mailbox bit of core c whose write-data bit is 1. A read at this address returns the current mailbox word.
- R5: A set or clear write that targets one core leaves the mailboxes of all other cores unchanged.
- R6: Writing to 0x08 ORs the write data into the 4-bit routing mask. Writing to 0x0C clears the mask bits that are written as 1. Both addresses read back the mask.
- R7: The mailbox enable register of core c is at 0x50+4c. Only bit 0 is stored; the other bits read as 0.
- R8: The read-only status word of core c is at 0x60+4c, and writes to it are ignored. Bits 3:0 are the timer inputs ANDed with their enables. Bit 4 is (mailbox != 0) AND the mailbox enable. Bit 8 is `periph_irq[c]`. Bit 9 is `pmu_irq[c]` AND routing bit c. All other bits are 0.
- R9: `irq[c]` is the OR of core c's status word, registered once. It changes one clock after the status word changes.
- R10: Reads of unmapped addresses return 0, and writes to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Write strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| timer_irq | input | 4*N_CORES | Timer requests, four per core |
| periph_irq | input | N_CORES | Peripheral request per core |
| pmu_irq | input | N_CORES | Performance-monitor request per core |
| irq | output | N_CORES | Interrupt line per core |

## Verification
The bench builds the block with the default of four cores. With four cores, the last core's mailbox sits at the top of the address space, at 0xF0, so stride decoding is exercised up to its upper edge. Four cores also allow the bench to set, clear and observe neighbouring mailboxes, which shows that writes to one core do not reach the others. The bench sets the routing mask so that some cores are routed and others are not. It then drives all timer inputs together against unequal enable masks, which exposes any bit-order or per-core mix-up in the status word.

// File: rtl/core_irq_ctrl.sv
module core_irq_ctrl #(
  parameter int N_CORES = 4,
  parameter int MB_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [7:0]           addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [4*N_CORES-1:0] timer_irq,
  input  logic [N_CORES-1:0]   periph_irq,
  input  logic [N_CORES-1:0]   pmu_irq,
  output logic [N_CORES-1:0]   irq
);
  localparam logic [7:0] A_RT_SET = 8'h08;
  localparam logic [7:0] A_RT_CLR = 8'h0C;
  localparam logic [7:0] A_TMR    = 8'h40;
  localparam logic [7:0] A_MEN    = 8'h50;
  localparam logic [7:0] A_STAT   = 8'h60;
  localparam logic [7:0] A_MSET   = 8'h80;
  localparam logic [7:0] A_MCLR   = 8'hC0;

  logic [N_CORES-1:0][3:0]      tmr_en_q;
  logic [N_CORES-1:0]           men_q;
  logic [N_CORES-1:0][MB_W-1:0] mbox_q;
  logic [N_CORES-1:0]           route_q;
  logic [N_CORES-1:0][31:0]     pend;

  for (genvar c = 0; c < N_CORES; c++) begin : g_pend
    assign pend[c] = {22'd0,
                      pmu_irq[c] & route_q[c],
                      periph_irq[c],
                      3'd0,
                      (|mbox_q[c]) & men_q[c],
                      timer_irq[4*c +: 4] & tmr_en_q[c]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_en_q <= '0;
      men_q    <= '0;
      mbox_q   <= '0;
      route_q  <= '0;
      irq      <= '0;
    end else begin
      for (int c = 0; c < N_CORES; c++) irq[c] <= |pend[c];
      if (we) begin
        if (addr == A_RT_SET) route_q <= route_q | wdata[N_CORES-1:0];
        if (addr == A_RT_CLR) route_q <= route_q & ~wdata[N_CORES-1:0];
        for (int c = 0; c < N_CORES; c++) begin
          if (addr == A_TMR + 8'(4*c))  tmr_en_q[c] <= wdata[3:0];
          if (addr == A_MEN + 8'(4*c))  men_q[c]    <= wdata[0];
          if (addr == A_MSET + 8'(16*c)) mbox_q[c]  <= mbox_q[c] | wdata[MB_W-1:0];
          if (addr == A_MCLR + 8'(16*c)) mbox_q[c]  <= mbox_q[c] & ~wdata[MB_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_RT_SET || addr == A_RT_CLR) rdata = 32'(route_q);
    for (int c = 0; c < N_CORES; c++) begin
      if (addr == A_TMR + 8'(4*c))  rdata = {28'd0, tmr_en_q[c]};
      if (addr == A_MEN + 8'(4*c))  rdata = {31'd0, men_q[c]};
      if (addr == A_STAT + 8'(4*c)) rdata = pend[c];
      if (addr == A_MSET + 8'(16*c) || addr == A_MCLR + 8'(16*c)) rdata = 32'(mbox_q[c]);
    end
  end
endmodule

// File: rtl/core_irq_ctrl_chk.sv
module core_irq_ctrl_chk #(
  parameter int N_CORES = 4,
  parameter int MB_W    = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         we,
  input logic [7:0]                   addr,
  input logic [31:0]                  wdata,
  input logic [4*N_CORES-1:0]         timer_irq,
  input logic [N_CORES-1:0]           irq,
  input logic [N_CORES-1:0][3:0]      tmr_en_q,
  input logic [N_CORES-1:0][MB_W-1:0] mbox_q,
  input logic [N_CORES-1:0][31:0]     pend
);
  for (genvar c = 0; c < N_CORES; c++) begin : g_c
    p_mbox_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 8'(8'h80 + 16*c)) |=>
        ((mbox_q[c] & $past(wdata[MB_W-1:0])) == $past(wdata[MB_W-1:0])));
    p_mbox_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 8'(8'hC0 + 16*c)) |=> ((mbox_q[c] & $past(wdata[MB_W-1:0])) == '0));
    p_mbox_iso_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr != 8'(8'h80 + 16*c) && addr != 8'(8'hC0 + 16*c)) |=> $stable(mbox_q[c]));
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[c] == 32'd0) |=> !irq[c]);
    for (genvar j = 0; j < 4; j++) begin : g_t
      p_timer_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_irq[4*c+j] && tmr_en_q[c][j]) |=> irq[c]);
    end
  end
endmodule

bind core_irq_ctrl core_irq_ctrl_chk #(.N_CORES(N_CORES), .MB_W(MB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .timer_irq(timer_irq), .irq(irq), .tmr_en_q(tmr_en_q), .mbox_q(mbox_q), .pend(pend));

// File: tb/tb_core_irq_ctrl.sv
module tb_core_irq_ctrl;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [4*N-1:0] timer_irq = '0;
  logic [N-1:0] periph_irq = '0, pmu_irq = '0, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  core_irq_ctrl #(.N_CORES(N)) dut (.*);

  // fields: wr_addr, wr_data, rd_addr, expected
  localparam int NV = 13;
  localparam logic [79:0] VEC [NV] = '{
    {8'h44, 32'hFFFF_FFFF, 8'h44, 32'h0000_000F},  // R2
    {8'h40, 32'h0000_0005, 8'h40, 32'h0000_0005},  // R2
    {8'h90, 32'h8000_0001, 8'h90, 32'h8000_0001},  // R3
    {8'h90, 32'h0000_0100, 8'hD0, 32'h8000_0101},  // R3
    {8'hD0, 32'h0000_0001, 8'hD0, 32'h8000_0100},  // R4
    {8'hA0, 32'hFFFF_0000, 8'hD0, 32'h8000_0100},  // R5
    {8'hF0, 32'hFFFF_FFFF, 8'hE0, 32'hFFFF_0000},  // R5
    {8'h08, 32'h0000_0004, 8'h0C, 32'h0000_0004},  // R6
    {8'h08, 32'h0000_0001, 8'h08, 32'h0000_0005},  // R6
    {8'h0C, 32'h0000_0004, 8'h08, 32'h0000_0001},  // R6
    {8'h54, 32'h0000_0003, 8'h54, 32'h0000_0001},  // R7
    {8'h64, 32'hFFFF_FFFF, 8'h64, 32'h0000_0010},  // R8
    {8'h30, 32'hFFFF_FFFF, 8'h30, 32'h0000_0000}   // R10
  };
  localparam string TAG [NV] = '{"R2","R2","R3","R3","R4","R5","R5","R6","R6","R6","R7","R8","R10"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    automatic logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h40, v); chk("R1 timer enable after reset", v, 0);
    rd(8'hC0, v); chk("R1 mailbox after reset", v, 0);
    chk("R1 irq after reset", 32'(irq), 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][79:72], VEC[i][71:40]);
      rd(VEC[i][39:32], v);
      chk(TAG[i], v, VEC[i][31:0]);
    end

    @(negedge clk);
    chk("R9 core1 mailbox irq", 32'(irq[1]), 1);
    rd(8'h68, v); chk("R8 core2 mailbox disabled", v, 0);
    chk("R9 core2 quiet", 32'(irq[2]), 0);

    @(negedge clk); timer_irq = '1;
    rd(8'h60, v); chk("R8 core0 timers", v, 32'h5);
    rd(8'h64, v); chk("R8 core1 timers+mailbox", v, 32'h1F);
    chk("R9 irq latency core0", 32'(irq[0]), 0);
    @(negedge clk);
    chk("R9 irq core0 after one clock", 32'(irq[0]), 1);
    timer_irq = '0; periph_irq = 4'b1000; pmu_irq = 4'b0101;
    rd(8'h60, v); chk("R8 core0 pmu routed", v, 32'h200);
    rd(8'h68, v); chk("R8 core2 pmu not routed", v, 0);
    rd(8'h6C, v); chk("R8 core3 peripheral", v, 32'h100);
    @(negedge clk);
    chk("R9 irq vector", 32'(irq), 32'hB);

    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1; periph_irq = '0; pmu_irq = '0;
    rd(8'h08, v); chk("R1 routing cleared", v, 0);
    rd(8'hD0, v); chk("R1 mailbox cleared", v, 0);
    rd(8'h54, v); chk("R1 mailbox enable cleared", v, 0);
    @(negedge clk);
    chk("R1 irq cleared", 32'(irq), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule